// File: doc/BRIEF.md
# Operand Effective Address Generator

This block forms operand and branch-target addresses for a 16-bit processor whose memory is addressed by byte. For every operand step the decoder presents an addressing-mode code, a byte/word size flag, the selected general register, the program counter and the instruction bytes that carry addresses, immediates or displacements. The block returns the effective address, an immediate operand, a register write-back value with its enable for the auto-increment and auto-decrement modes, a misalignment flag and an illegal-operand flag. All of these follow the inputs within the same cycle.

The memory-indirect jump takes more than one cycle. The block reads a 16-bit pointer word from the top 256-byte page over a request/valid handshake. It then reports the word it read as the branch target, together with a one-cycle done pulse. While that fetch is in flight, the single-cycle address paths stay live. A second memory-indirect start is ignored until the first one completes.

Top module: `eag_top`

## Requirements
- R1: Mode code 0 (post-increment): with `op_start` high, `ea` equals `reg_val`, `wb_val` equals `reg_val` plus 1 for a byte operand or plus 2 for a word operand, and `wb_en` is 1.
- R2: Mode code 1 (pre-decrement): with `op_start` high, `ea` and `wb_val` both equal `reg_val` minus 1 for a byte operand or minus 2 for a word operand, and `wb_en` is 1.
- R3: `misalign` is 1 when a word-sized mode 0 or 1 step has bit 0 of `reg_val` set, and when a mode 8 step has bit 0 of `ibyte2` set. A byte-sized mode 0 or 1 step never raises it.
- R4: Mode code 2 (short absolute) gives `ea` = {0xFF, `ibyte2`}. Mode code 3 (long absolute) gives `ea` = `ibyte34`, unchanged.
- R5: Mode code 4 gives `imm_out` = {0x00, `ibyte2`}. Mode code 5 gives `imm_out` = `ibyte34` when `size_word` is 1. With a byte size, mode code 5 gives `imm_out` = 0 and raises `op_illegal`.
- R6: Mode code 6 gives `imm_out` = 2 when `impl_two` is 1 and 1 otherwise. Mode code 7 gives `imm_out` = bits [6:4] of `ibyte2` when `bitno_hi` is 0, or bits [6:4] of `ibyte34[7:0]` when it is 1, zero-extended.
- R7: Mode code 8 (PC-relative) gives `ea` = `pc_val` + the sign-extended `ibyte2`. `pc_val` is taken to be already advanced by 2 past the instruction.
- R8: Every address sum and difference wraps modulo 2^16.
- R9: `wb_en` is 1 only while `op_start` is high with mode 0 or 1. With `op_start` low, `ea`, `imm_out`, `wb_val`, `misalign` and `op_illegal` are all 0.
- R10: A mode 9 (memory-indirect) start raises `rd_req` from the next cycle, with `rd_addr` = {0xFF, `ibyte2`}. `rd_req` and `rd_addr` hold until a cycle in which `rd_valid` is 1.
- R11: In the cycle after `rd_valid` is accepted, `tgt_done` is high for exactly one cycle, with `tgt_addr` equal to the `rd_data` that was accepted. `busy` is 1 from the cycle after the start through the done cycle.
- R12: A mode 9 start while `busy` is 1 is ignored: it causes no extra request and no extra done pulse.
- R13: After reset, `rd_req`, `tgt_done` and `busy` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| op_start | input | 1 | Operand step valid this cycle |
| mode | input | 4 | Addressing-mode code (0..9) |
| size_word | input | 1 | 1 = word operand, 0 = byte |
| reg_val | input | 16 | Selected general register contents |
| pc_val | input | 16 | Program counter, already advanced by 2 |
| ibyte2 | input | 8 | Second instruction byte |
| ibyte34 | input | 16 | Third and fourth instruction bytes |
| impl_two | input | 1 | Implicit constant is 2 (else 1) |
| bitno_hi | input | 1 | Bit number taken from the fourth byte |
| ea | output | 16 | Effective address |
| imm_out | output | 16 | Immediate operand |
| wb_en | output | 1 | Register write-back enable |
| wb_val | output | 16 | Register write-back value |
| misalign | output | 1 | Alignment violation |
| op_illegal | output | 1 | Long immediate with a byte size |
| rd_req | output | 1 | Pointer read request |
| rd_addr | output | 16 | Pointer read address |
| rd_valid | input | 1 | Pointer read data valid |
| rd_data | input | 16 | Pointer read data |
| tgt_done | output | 1 | Indirect target ready pulse |
| tgt_addr | output | 16 | Indirect branch target |
| busy | output | 1 | Indirect fetch in progress |

## Verification
Two functions can coincide in one cycle: the done pulse of a memory-indirect fetch, and a single-cycle step with write-back. To provoke this, the bench issues a word post-increment on an odd register in exactly the cycle when `tgt_done` is high. It then checks that the target, the write-back value and the misalignment flag are all correct together. A second mode 9 start is also sent while a fetch waits for data. The bench judges it by the unchanged `rd_addr` and by a single done pulse.

// File: rtl/eag_pkg.sv
// Package: shared widths and addressing-mode codes for the effective
// address generator. Assumes a 16-bit address space addressed by byte.
package eag_pkg;
    localparam int EAG_AW = 16;
    localparam int EAG_BW = 8;

    typedef enum logic [3:0] {
        AM_POSTINC = 4'd0,
        AM_PREDEC  = 4'd1,
        AM_ABS8    = 4'd2,
        AM_ABS16   = 4'd3,
        AM_IMM8    = 4'd4,
        AM_IMM16   = 4'd5,
        AM_IMPL    = 4'd6,
        AM_BITNO   = 4'd7,
        AM_PCREL   = 4'd8,
        AM_MEMIND  = 4'd9
    } eag_mode_e;

    typedef enum logic [1:0] {
        IND_IDLE  = 2'd0,
        IND_FETCH = 2'd1,
        IND_DONE  = 2'd2
    } eag_ind_e;
endpackage

// File: rtl/eag_autostep.sv
// Auto-increment / auto-decrement path. Post-increment uses the register
// as the address and writes back the stepped value. Pre-decrement steps
// first, then uses and writes back the result. The step is 1 for byte
// operands and 2 for word operands; sums wrap modulo 2^AW. Assumes the
// caller gates the outputs by mode.
module eag_autostep #(
    parameter int AW = 16
) (
    input  logic          is_dec,
    input  logic          size_word,
    input  logic [AW-1:0] reg_val,
    output logic [AW-1:0] addr,
    output logic [AW-1:0] next_val,
    output logic          odd_word
);
    localparam logic [AW-1:0] STEP_B = AW'(1);
    localparam logic [AW-1:0] STEP_W = AW'(2);

    logic [AW-1:0] step;

    // Choose the step size from the operand size.
    always_comb begin
        step = size_word ? STEP_W : STEP_B;
    end

    // Form the address and the write-back value for either direction.
    always_comb begin
        if (is_dec) begin
            next_val = reg_val - step;
            addr     = next_val;
        end else begin
            next_val = reg_val + step;
            addr     = reg_val;
        end
        odd_word = size_word & reg_val[0];
    end
endmodule

// File: rtl/eag_direct.sv
// Direct address forms: short absolute (forced into the top page),
// long absolute, and PC-relative with a sign-extended byte displacement.
// Assumes pc_val already points 2 bytes past the instruction.
module eag_direct #(
    parameter int AW = 16,
    parameter int BW = 8
) (
    input  logic [BW-1:0] short_off,
    input  logic [AW-1:0] long_addr,
    input  logic [AW-1:0] pc_val,
    output logic [AW-1:0] page_addr,
    output logic [AW-1:0] abs_addr,
    output logic [AW-1:0] rel_addr,
    output logic          rel_odd
);
    localparam int HI = AW - BW;

    logic [AW-1:0] disp_ext;

    // Expand the short offset into the all-ones page.
    always_comb begin
        page_addr = {{HI{1'b1}}, short_off};
        abs_addr  = long_addr;
    end

    // Sign-extend the displacement and add it to the program counter.
    always_comb begin
        disp_ext = {{HI{short_off[BW-1]}}, short_off};
        rel_addr = pc_val + disp_ext;
        rel_odd  = short_off[0];
    end
endmodule

// File: rtl/eag_imm.sv
// Immediate operand source: byte immediate, word immediate (word size
// only), implicit constant 1 or 2, and a 3-bit bit number taken from the
// second or the fourth instruction byte. Assumes mode decoding upstream.
module eag_imm #(
    parameter int AW = 16,
    parameter int BW = 8
) (
    input  logic [3:0]    mode,
    input  logic          size_word,
    input  logic [BW-1:0] ibyte2,
    input  logic [AW-1:0] ibyte34,
    input  logic          impl_two,
    input  logic          bitno_hi,
    output logic [AW-1:0] imm,
    output logic          illegal
);
    import eag_pkg::*;

    localparam int BITNO_LSB = 4;
    localparam int BITNO_W   = 3;

    logic [BW-1:0]      bsrc;
    logic [BITNO_W-1:0] bitno;

    // Select the byte that holds the bit number and extract it.
    always_comb begin
        bsrc  = bitno_hi ? ibyte34[BW-1:0] : ibyte2;
        bitno = bsrc[BITNO_LSB +: BITNO_W];
    end

    // Choose the immediate value by mode.
    always_comb begin
        imm     = '0;
        illegal = 1'b0;
        case (eag_mode_e'(mode))
            AM_IMM8:  imm = AW'(ibyte2);
            AM_IMM16: begin
                if (size_word) imm = ibyte34;
                else           illegal = 1'b1;
            end
            AM_IMPL:  imm = impl_two ? AW'(2) : AW'(1);
            AM_BITNO: imm = AW'(bitno);
            default:  imm = '0;
        endcase
    end
endmodule

// File: rtl/eag_ind_fsm.sv
// Memory-indirect fetch sequencer. On a launch it latches the pointer
// address, holds a read request until valid data arrives, then presents
// the data as the branch target with a one-cycle done pulse. Launches
// while busy are dropped. Assumes rd_data is meaningful only with rd_valid.
module eag_ind_fsm #(
    parameter int AW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          launch,
    input  logic [AW-1:0] ptr_addr,
    input  logic          rd_valid,
    input  logic [AW-1:0] rd_data,
    output logic          rd_req,
    output logic [AW-1:0] rd_addr,
    output logic          tgt_done,
    output logic [AW-1:0] tgt_addr,
    output logic          busy
);
    import eag_pkg::*;

    eag_ind_e      state, state_nx;
    logic [AW-1:0] ptr_q;
    logic [AW-1:0] tgt_q;

    // Next-state decision for the fetch sequence.
    always_comb begin
        state_nx = state;
        case (state)
            IND_IDLE:  if (launch) state_nx = IND_FETCH;
            IND_FETCH: if (rd_valid) state_nx = IND_DONE;
            IND_DONE:  state_nx = IND_IDLE;
            default:   state_nx = IND_IDLE;
        endcase
    end

    // State register with synchronous active-low reset.
    always_ff @(posedge clk) begin
        if (!rst_n) state <= IND_IDLE;
        else        state <= state_nx;
    end

    // Capture the pointer on launch and the target on data arrival.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ptr_q <= '0;
            tgt_q <= '0;
        end else begin
            if (state == IND_IDLE && launch)    ptr_q <= ptr_addr;
            if (state == IND_FETCH && rd_valid) tgt_q <= rd_data;
        end
    end

    // Drive the handshake and result outputs from state.
    always_comb begin
        rd_req   = (state == IND_FETCH);
        rd_addr  = ptr_q;
        tgt_done = (state == IND_DONE);
        tgt_addr = tgt_q;
        busy     = (state != IND_IDLE);
    end
endmodule

// File: rtl/eag_top.sv
// Effective address generator top. Decodes the mode code, steers the
// single-cycle address and immediate paths to the outputs (all zero when
// op_start is low), and launches the memory-indirect fetch sequencer.
// Assumes the decoder holds inputs stable for the cycle of op_start.
module eag_top #(
    parameter int AW = eag_pkg::EAG_AW,
    parameter int BW = eag_pkg::EAG_BW
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          op_start,
    input  logic [3:0]    mode,
    input  logic          size_word,
    input  logic [AW-1:0] reg_val,
    input  logic [AW-1:0] pc_val,
    input  logic [BW-1:0] ibyte2,
    input  logic [AW-1:0] ibyte34,
    input  logic          impl_two,
    input  logic          bitno_hi,
    output logic [AW-1:0] ea,
    output logic [AW-1:0] imm_out,
    output logic          wb_en,
    output logic [AW-1:0] wb_val,
    output logic          misalign,
    output logic          op_illegal,
    output logic          rd_req,
    output logic [AW-1:0] rd_addr,
    input  logic          rd_valid,
    input  logic [AW-1:0] rd_data,
    output logic          tgt_done,
    output logic [AW-1:0] tgt_addr,
    output logic          busy
);
    import eag_pkg::*;

    eag_mode_e     md;
    logic          sel_step;
    logic [AW-1:0] step_addr, step_next;
    logic          step_odd;
    logic [AW-1:0] page_addr, abs_addr, rel_addr;
    logic          rel_odd;
    logic [AW-1:0] imm_raw;
    logic          imm_bad;

    // Decode which single-cycle path is active.
    always_comb begin
        md       = eag_mode_e'(mode);
        sel_step = (md == AM_POSTINC) || (md == AM_PREDEC);
    end

    eag_autostep #(.AW(AW)) u_step (
        .is_dec    (md == AM_PREDEC),
        .size_word (size_word),
        .reg_val   (reg_val),
        .addr      (step_addr),
        .next_val  (step_next),
        .odd_word  (step_odd)
    );

    eag_direct #(.AW(AW), .BW(BW)) u_direct (
        .short_off (ibyte2),
        .long_addr (ibyte34),
        .pc_val    (pc_val),
        .page_addr (page_addr),
        .abs_addr  (abs_addr),
        .rel_addr  (rel_addr),
        .rel_odd   (rel_odd)
    );

    eag_imm #(.AW(AW), .BW(BW)) u_imm (
        .mode      (mode),
        .size_word (size_word),
        .ibyte2    (ibyte2),
        .ibyte34   (ibyte34),
        .impl_two  (impl_two),
        .bitno_hi  (bitno_hi),
        .imm       (imm_raw),
        .illegal   (imm_bad)
    );

    eag_ind_fsm #(.AW(AW)) u_ind (
        .clk      (clk),
        .rst_n    (rst_n),
        .launch   (op_start && md == AM_MEMIND),
        .ptr_addr (page_addr),
        .rd_valid (rd_valid),
        .rd_data  (rd_data),
        .rd_req   (rd_req),
        .rd_addr  (rd_addr),
        .tgt_done (tgt_done),
        .tgt_addr (tgt_addr),
        .busy     (busy)
    );

    // Steer the effective address by mode.
    always_comb begin
        ea = '0;
        if (op_start) begin
            case (md)
                AM_POSTINC, AM_PREDEC: ea = step_addr;
                AM_ABS8, AM_MEMIND:    ea = page_addr;
                AM_ABS16:              ea = abs_addr;
                AM_PCREL:              ea = rel_addr;
                default:               ea = '0;
            endcase
        end
    end

    // Gate the immediate, write-back and flag outputs by the step strobe.
    always_comb begin
        imm_out    = op_start ? imm_raw : '0;
        op_illegal = op_start & imm_bad;
        wb_en      = op_start & sel_step;
        wb_val     = (op_start && sel_step) ? step_next : '0;
        misalign   = op_start & ((sel_step & step_odd) |
                                 ((md == AM_PCREL) & rel_odd));
    end
endmodule

// File: rtl/eag_chk.sv
// Checker for eag_top: temporal properties on the ports, bound below.
module eag_chk #(
    parameter int AW = 16
) (
    input logic          clk,
    input logic          rst_n,
    input logic          op_start,
    input logic [3:0]    mode,
    input logic          size_word,
    input logic [AW-1:0] ea,
    input logic          wb_en,
    input logic          misalign,
    input logic          rd_req,
    input logic [AW-1:0] rd_addr,
    input logic          rd_valid,
    input logic [AW-1:0] rd_data,
    input logic          tgt_done,
    input logic [AW-1:0] tgt_addr,
    input logic          busy
);
    a_r10_req_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_req && !rd_valid) |=> (rd_req && $stable(rd_addr)));

    a_r11_done_after_data: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_req && rd_valid) |=> (tgt_done && tgt_addr == $past(rd_data)));

    a_r11_done_single: assert property (@(posedge clk) disable iff (!rst_n)
        tgt_done |=> !tgt_done);

    a_r11_busy_covers: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_req || tgt_done) |-> busy);

    a_r9_wb_only_step: assert property (@(posedge clk) disable iff (!rst_n)
        wb_en |-> (op_start && (mode == 4'd0 || mode == 4'd1)));

    a_r3_byte_aligned: assert property (@(posedge clk) disable iff (!rst_n)
        (op_start && !size_word && (mode == 4'd0 || mode == 4'd1)) |-> !misalign);

    a_r4_short_page: assert property (@(posedge clk) disable iff (!rst_n)
        (op_start && mode == 4'd2) |-> (ea[AW-1:AW-8] == 8'hFF));
endmodule

bind eag_top eag_chk #(.AW(AW)) u_chk (
    .clk(clk), .rst_n(rst_n), .op_start(op_start), .mode(mode),
    .size_word(size_word), .ea(ea), .wb_en(wb_en), .misalign(misalign),
    .rd_req(rd_req), .rd_addr(rd_addr), .rd_valid(rd_valid),
    .rd_data(rd_data), .tgt_done(tgt_done), .tgt_addr(tgt_addr), .busy(busy)
);

// File: tb/sim_eag_top.sv
module sim_eag_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        op_start = 1'b0;
    logic [3:0]  mode = '0;
    logic        size_word = 1'b0;
    logic [15:0] reg_val = '0, pc_val = '0, ibyte34 = '0, rd_data = '0;
    logic [7:0]  ibyte2 = '0;
    logic        impl_two = 1'b0, bitno_hi = 1'b0, rd_valid = 1'b0;
    logic [15:0] ea, imm_out, wb_val, rd_addr, tgt_addr;
    logic        wb_en, misalign, op_illegal, rd_req, tgt_done, busy;

    int n_chk = 0;
    int n_bad = 0;

    always #2 clk = ~clk;

    eag_top u0 (
        .clk(clk), .rst_n(rst_n), .op_start(op_start), .mode(mode),
        .size_word(size_word), .reg_val(reg_val), .pc_val(pc_val),
        .ibyte2(ibyte2), .ibyte34(ibyte34), .impl_two(impl_two),
        .bitno_hi(bitno_hi), .ea(ea), .imm_out(imm_out), .wb_en(wb_en),
        .wb_val(wb_val), .misalign(misalign), .op_illegal(op_illegal),
        .rd_req(rd_req), .rd_addr(rd_addr), .rd_valid(rd_valid),
        .rd_data(rd_data), .tgt_done(tgt_done), .tgt_addr(tgt_addr),
        .busy(busy)
    );

    task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Drive one step at the falling edge and let combinational paths settle.
    task automatic step(input logic st, input logic [3:0] m, input logic sw,
                        input logic [15:0] r, input logic [15:0] pc,
                        input logic [7:0] b2, input logic [15:0] b34);
        @(negedge clk);
        op_start = st; mode = m; size_word = sw; reg_val = r;
        pc_val = pc; ibyte2 = b2; ibyte34 = b34;
        #1;
    endtask

    task automatic t_reset();
        chk("R13 rd_req", 16'(rd_req), 16'd0);
        chk("R13 tgt_done", 16'(tgt_done), 16'd0);
        chk("R13 busy", 16'(busy), 16'd0);
    endtask

    task automatic t_postinc();
        step(1, 0, 0, 16'h1235, 0, 0, 0);
        chk("R1 ea byte", ea, 16'h1235);
        chk("R1 wb byte", wb_val, 16'h1236);
        chk("R1 wb_en", 16'(wb_en), 16'd1);
        chk("R3 byte odd no flag", 16'(misalign), 16'd0);
        step(1, 0, 1, 16'hFFFE, 0, 0, 0);
        chk("R1 ea word", ea, 16'hFFFE);
        chk("R8 wb wrap", wb_val, 16'h0000);
        chk("R3 word even", 16'(misalign), 16'd0);
        step(1, 0, 1, 16'h4001, 0, 0, 0);
        chk("R3 word odd", 16'(misalign), 16'd1);
    endtask

    task automatic t_predec();
        step(1, 1, 1, 16'h2000, 0, 0, 0);
        chk("R2 ea word", ea, 16'h1FFE);
        chk("R2 wb word", wb_val, 16'h1FFE);
        step(1, 1, 0, 16'h0000, 0, 0, 0);
        chk("R8 ea byte wrap", ea, 16'hFFFF);
        chk("R2 wb byte", wb_val, 16'hFFFF);
        chk("R2 wb_en", 16'(wb_en), 16'd1);
    endtask

    task automatic t_absolute();
        step(1, 2, 0, 0, 0, 8'h34, 16'h9999);
        chk("R4 short abs", ea, 16'hFF34);
        chk("R9 no wb abs", 16'(wb_en), 16'd0);
        step(1, 3, 1, 16'h5555, 0, 8'h34, 16'h1234);
        chk("R4 long abs", ea, 16'h1234);
    endtask

    task automatic t_imm();
        step(1, 4, 0, 0, 0, 8'hA5, 16'h7777);
        chk("R5 imm8", imm_out, 16'h00A5);
        step(1, 5, 1, 0, 0, 8'hA5, 16'hBEEF);
        chk("R5 imm16 word", imm_out, 16'hBEEF);
        chk("R5 legal", 16'(op_illegal), 16'd0);
        step(1, 5, 0, 0, 0, 8'hA5, 16'hBEEF);
        chk("R5 imm16 byte val", imm_out, 16'h0000);
        chk("R5 imm16 byte illegal", 16'(op_illegal), 16'd1);
        impl_two = 1'b0;
        step(1, 6, 0, 0, 0, 0, 0);
        chk("R6 const one", imm_out, 16'd1);
        impl_two = 1'b1;
        step(1, 6, 0, 0, 0, 0, 0);
        chk("R6 const two", imm_out, 16'd2);
        bitno_hi = 1'b0;
        step(1, 7, 0, 0, 0, 8'b1101_0000, 16'h0020);
        chk("R6 bitno byte2", imm_out, 16'd5);
        bitno_hi = 1'b1;
        step(1, 7, 0, 0, 0, 8'b1101_0000, 16'h0060);
        chk("R6 bitno byte4", imm_out, 16'd6);
        bitno_hi = 1'b0; impl_two = 1'b0;
    endtask

    task automatic t_pcrel();
        step(1, 8, 0, 0, 16'h1000, 8'h80, 0);
        chk("R7 back 128", ea, 16'h0F80);
        chk("R7 even disp", 16'(misalign), 16'd0);
        step(1, 8, 0, 0, 16'h1000, 8'h7E, 0);
        chk("R7 fwd 126", ea, 16'h107E);
        step(1, 8, 0, 0, 16'hFFF0, 8'h20, 0);
        chk("R8 pc wrap", ea, 16'h0010);
        step(1, 8, 0, 0, 16'h1000, 8'h03, 0);
        chk("R3 odd disp", 16'(misalign), 16'd1);
    endtask

    task automatic t_idle_zero();
        step(0, 0, 1, 16'h1235, 0, 8'h44, 16'h4444);
        chk("R9 ea idle", ea, 16'h0000);
        chk("R9 wb_en idle", 16'(wb_en), 16'd0);
        chk("R9 wb_val idle", wb_val, 16'h0000);
        chk("R9 misalign idle", 16'(misalign), 16'd0);
    endtask

    // Memory-indirect fetch, second start while busy, overlap with post-increment.
    task automatic t_indirect();
        int dones = 0;
        step(1, 9, 1, 0, 0, 8'h10, 0);
        chk("R10 pointer ea", ea, 16'hFF10);
        step(0, 0, 0, 0, 0, 0, 0);
        chk("R10 req up", 16'(rd_req), 16'd1);
        chk("R10 rd_addr", rd_addr, 16'hFF10);
        chk("R11 busy", 16'(busy), 16'd1);
        step(1, 9, 1, 0, 0, 8'h20, 0);
        chk("R12 addr kept", rd_addr, 16'hFF10);
        step(0, 0, 0, 0, 0, 0, 0);
        chk("R10 req held", 16'(rd_req), 16'd1);
        chk("R12 addr still", rd_addr, 16'hFF10);
        rd_valid = 1'b1; rd_data = 16'hC0DE;
        step(1, 0, 1, 16'h3001, 0, 0, 0);
        rd_valid = 1'b0; rd_data = 16'h0000;
        chk("R11 done", 16'(tgt_done), 16'd1);
        chk("R11 target", tgt_addr, 16'hC0DE);
        chk("R1 overlap wb", wb_val, 16'h3003);
        chk("R3 overlap misalign", 16'(misalign), 16'd1);
        if (tgt_done) dones++;
        for (int i = 0; i < 4; i++) begin
            step(0, 0, 0, 0, 0, 0, 0);
            if (tgt_done) dones++;
            chk("R12 no new req", 16'(rd_req), 16'd0);
        end
        chk("R11 one pulse", 16'(dones), 16'd1);
        chk("R11 idle after", 16'(busy), 16'd0);
    endtask

    initial begin : watchdog
        repeat (5000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        #1;
        t_reset();
        t_postinc();
        t_predec();
        t_absolute();
        t_imm();
        t_pcrel();
        t_idle_zero();
        t_indirect();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
        $finish;
    end
endmodule